// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit

This block is the multiply execution unit of a 64-bit integer core. Each cycle it can accept two operands and a small operation record. The record holds an operation code, a signed flag, a word-mode flag, a context tag and the incoming sticky summary-overflow bit. Three clocks later it presents the formatted product, a two-bit overflow field and the untouched record.

There are three operations: the low half of a product, the upper half of a full-width product, and the upper half of a half-width product. The half-width upper result is repeated into both halves of the output word. Signed products are formed from operand magnitudes and then negated when the operand signs differ. Only the low-product operation reports overflow. Overflow is flagged when the product bits just above the kept result disagree with its top bit. The flag drives both bits of the overflow field.

The pipeline has no back-pressure. A valid bit moves forward with its data on every clock, so a new operation can enter every cycle. With the default parameters the full width X is 64, the half width H is 32 and the tag is 2 bits.

Top module: `mul_pipe`

## Requirements
- R1: `out_valid` equals the value `in_valid` had three rising edges earlier. The pipeline never stalls, so operations on consecutive cycles leave on consecutive cycles.
- R2: `out_op`, `out_signed`, `out_word`, `out_tag` and `out_so` equal the values presented with the operation, aligned with its result.
- R3: Operation code 2'b01 (half high) multiplies bits H-1..0 of both operands into a 2H-bit product. When `in_signed`=1 those bits are taken as two's complement, using bit H-1 as the sign. The result is product bits 2H-1..H placed in both the upper and the lower H bits of `out_result`.
- R4: Operation code 2'b10 (full high) returns bits 2X-1..X of the 2X-bit product of the full operands. The product is signed when `in_signed`=1 (sign bit X-1) and unsigned otherwise.
- R5: Operation code 2'b00 with `in_word`=1 returns the X-bit product of bits H-1..0 of both operands. The product is signed when `in_signed`=1 and unsigned otherwise.
- R6: Operation code 2'b00 with `in_word`=0 is always a signed product, whatever `in_signed` is. It returns product bits X-1..0.
- R7: For the low operation with `in_word`=1, overflow is raised when product bits X-1..H-1 are neither all zeros nor all ones.
- R8: For the low operation with `in_word`=0, overflow is raised when bits 2X-1..X-1 of the 2X-bit signed product are neither all zeros nor all ones.
- R9: Both bits of `out_ov` carry the overflow flag. For the high operations `out_ov` is 2'b00 and `out_ov_ok` is 0. For low operations `out_ov_ok` is 1.
- R10: Operation code 2'b11 behaves exactly like code 2'b00.
- R11: A synchronous active-low reset clears `out_valid`, `out_result`, `out_ov` and `out_ov_ok` at the next rising edge, even when operations are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_op | input | 2 | Operation code: 00 low, 01 half high, 10 full high, 11 low |
| in_signed | input | 1 | Signed product |
| in_word | input | 1 | Word (half-width) mode |
| in_tag | input | 2 | Context tag carried with the operation |
| in_so | input | 1 | Incoming summary-overflow bit |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Formatted product |
| out_ov | output | 2 | Overflow flag, duplicated |
| out_ov_ok | output | 1 | Overflow field is meaningful (low operations) |
| out_op | output | 2 | Operation code of this result |
| out_signed | output | 1 | Signed flag of this result |
| out_word | output | 1 | Word flag of this result |
| out_tag | output | 2 | Context tag of this result |
| out_so | output | 1 | Summary-overflow bit of this result |

## Verification
A fault in the first stage shows at the ports exactly three cycles later. A wrong sign bit, half/full selection or magnitude gives a product whose sign or size is off, most visibly for the most negative operand of each width. A fault in the multiply or format stage shows one or two cycles after its cause. It appears as a wrong result half, a lost duplication in the half-high result, or an overflow flag that misreads the boundary between all-ones and mixed upper bits. Record or valid misalignment shows on the very next result as a tag or valid bit paired with the wrong product.

// File: rtl/mul_pkg.sv
// Shared types for the multiply pipeline.
// Assumes: operation codes are fixed at two bits; widths live in module parameters.
package mul_pkg;

    typedef enum logic [1:0] {
        MOP_LOW       = 2'b00,
        MOP_HIGH_HALF = 2'b01,
        MOP_HIGH_FULL = 2'b10,
        MOP_LOW_ALT   = 2'b11
    } mul_op_e;

    typedef struct packed {
        logic [1:0] op;
        logic       sgn;
        logic       word;
        logic       so;
    } mul_ctl_t;

endpackage

// File: rtl/mul_prep.sv
// Stage 1: operand preparation.
// Picks the active width (half or full), the signedness in effect and the sign bit
// of each operand, then registers operand magnitudes and the product-negate flag.
// Assumes XLEN is even. Magnitudes are unsigned and zero-extended to XLEN.
module mul_prep
    import mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TAG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   in_a,
    input  logic [XLEN-1:0]   in_b,
    input  mul_ctl_t          in_ctl,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              s1_valid,
    output logic [XLEN-1:0]   s1_mag_a,
    output logic [XLEN-1:0]   s1_mag_b,
    output logic              s1_neg,
    output mul_ctl_t          s1_ctl,
    output logic [TAG_W-1:0]  s1_tag
);
    localparam int HALF = XLEN / 2;
    localparam int NOPS = 2;

    logic                       is_low;
    logic                       narrow;
    logic                       use_sign;
    logic [NOPS-1:0][XLEN-1:0]  opnd;
    logic [NOPS-1:0][XLEN-1:0]  mag;
    logic [NOPS-1:0]            sbit;

    // Decode width and signedness from the operation record.
    assign is_low   = (in_ctl.op == MOP_LOW) || (in_ctl.op == MOP_LOW_ALT);
    assign narrow   = (in_ctl.op == MOP_HIGH_HALF) || (is_low && in_ctl.word);
    assign use_sign = in_ctl.sgn || (is_low && !in_ctl.word);

    assign opnd[0] = in_a;
    assign opnd[1] = in_b;

    // One magnitude unit per operand.
    generate
        for (genvar gi = 0; gi < NOPS; gi++) begin : g_opnd
            logic [HALF-1:0] lo_part;
            logic [HALF-1:0] lo_neg;
            logic [XLEN-1:0] full_neg;
            assign lo_part  = opnd[gi][HALF-1:0];
            assign lo_neg   = -lo_part;
            assign full_neg = -opnd[gi];
            assign sbit[gi] = use_sign && (narrow ? opnd[gi][HALF-1] : opnd[gi][XLEN-1]);
            assign mag[gi]  = narrow ? {{(XLEN-HALF){1'b0}}, (sbit[gi] ? lo_neg : lo_part)}
                                     : (sbit[gi] ? full_neg : opnd[gi]);
        end
    endgenerate

    // Valid bit register, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Datapath register, no reset needed.
    always_ff @(posedge clk) begin
        s1_mag_a <= mag[0];
        s1_mag_b <= mag[1];
        s1_neg   <= sbit[0] ^ sbit[1];
        s1_ctl   <= in_ctl;
        s1_tag   <= in_tag;
    end

endmodule

// File: rtl/mul_core.sv
// Stage 2: unsigned magnitude multiply.
// Registers the 2*XLEN-bit product of the two magnitudes and forwards the record.
// Assumes magnitudes are unsigned.
module mul_core
    import mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TAG_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_valid,
    input  logic [XLEN-1:0]    s1_mag_a,
    input  logic [XLEN-1:0]    s1_mag_b,
    input  logic               s1_neg,
    input  mul_ctl_t           s1_ctl,
    input  logic [TAG_W-1:0]   s1_tag,
    output logic               s2_valid,
    output logic [2*XLEN-1:0]  s2_prod,
    output logic               s2_neg,
    output mul_ctl_t           s2_ctl,
    output logic [TAG_W-1:0]   s2_tag
);
    localparam int PW = 2 * XLEN;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] prod;

    // Widen both magnitudes so the product keeps every bit.
    assign ext_a = {{XLEN{1'b0}}, s1_mag_a};
    assign ext_b = {{XLEN{1'b0}}, s1_mag_b};
    assign prod  = ext_a * ext_b;

    // Valid bit register, synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= s1_valid;
    end

    // Product and record register.
    always_ff @(posedge clk) begin
        s2_prod <= prod;
        s2_neg  <= s1_neg;
        s2_ctl  <= s1_ctl;
        s2_tag  <= s1_tag;
    end

    // A zero magnitude must give a zero product (R5 and the other product forms).
    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s1_valid && ((s1_mag_a == '0) || (s1_mag_b == '0))) |-> (s2_prod == '0));

endmodule

// File: rtl/mul_format.sv
// Stage 3: sign restore, result selection and overflow detection.
// Applies the negate flag to the product, picks the result field for the operation
// and derives the duplicated overflow field. All outputs are reset.
module mul_format
    import mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TAG_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s2_valid,
    input  logic [2*XLEN-1:0]  s2_prod,
    input  logic               s2_neg,
    input  mul_ctl_t           s2_ctl,
    input  logic [TAG_W-1:0]   s2_tag,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_result,
    output logic [1:0]         out_ov,
    output logic               out_ov_ok,
    output mul_ctl_t           out_ctl,
    output logic [TAG_W-1:0]   out_tag
);
    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    logic [PW-1:0]        sprod;
    logic                 is_low;
    logic                 narrow;
    logic [HALF-1:0]      hi_half;
    logic [XLEN-HALF:0]   chunk_n;
    logic [XLEN:0]        chunk_f;
    logic                 ovf_n;
    logic                 ovf_f;
    logic                 ovf;
    logic [XLEN-1:0]      res;
    logic                 out_is_low;

    // Restore the product sign.
    assign sprod = s2_neg ? -s2_prod : s2_prod;

    // Decode the operation.
    assign is_low = (s2_ctl.op == MOP_LOW) || (s2_ctl.op == MOP_LOW_ALT);
    assign narrow = is_low && s2_ctl.word;

    // Overflow: the bits above the kept result must all match its top bit.
    assign chunk_n = sprod[XLEN-1:HALF-1];
    assign chunk_f = sprod[PW-1:XLEN-1];
    assign ovf_n   = (|chunk_n) && !(&chunk_n);
    assign ovf_f   = (|chunk_f) && !(&chunk_f);
    assign ovf     = is_low && (narrow ? ovf_n : ovf_f);

    // Result field selection.
    assign hi_half = sprod[XLEN-1:HALF];
    always_comb begin
        case (s2_ctl.op)
            MOP_HIGH_HALF: res = {hi_half, hi_half};
            MOP_HIGH_FULL: res = sprod[PW-1:XLEN];
            default:       res = sprod[XLEN-1:0];
        endcase
    end

    // Output register, synchronous reset on every field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_ov     <= 2'b00;
            out_ov_ok  <= 1'b0;
            out_ctl    <= '0;
            out_tag    <= '0;
        end else begin
            out_valid  <= s2_valid;
            out_result <= res;
            out_ov     <= {ovf, ovf};
            out_ov_ok  <= is_low;
            out_ctl    <= s2_ctl;
            out_tag    <= s2_tag;
        end
    end

    assign out_is_low = (out_ctl.op == MOP_LOW) || (out_ctl.op == MOP_LOW_ALT);

    // A positive full-width low product below 2^(XLEN-1) can never overflow.
    assert_small_no_ov_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s2_valid && is_low && !s2_ctl.word && !s2_neg && (s2_prod[PW-1:XLEN-1] == '0))
        |-> (out_ov == 2'b00));

    // High operations never report overflow and never raise the ok strobe.
    assert_high_no_ov_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_low) |-> ((out_ov == 2'b00) && !out_ov_ok));

endmodule

// File: rtl/mul_pipe.sv
// Top of the three-stage multiply unit: prepare, multiply, format.
// Assumes no stalls: a valid bit moves one stage on every clock.
module mul_pipe
    import mul_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int TAG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   in_a,
    input  logic [XLEN-1:0]   in_b,
    input  logic [1:0]        in_op,
    input  logic              in_signed,
    input  logic              in_word,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              in_so,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result,
    output logic [1:0]        out_ov,
    output logic              out_ov_ok,
    output logic [1:0]        out_op,
    output logic              out_signed,
    output logic              out_word,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_so
);
    mul_ctl_t               in_ctl;
    logic                   s1_valid;
    logic [XLEN-1:0]        s1_mag_a;
    logic [XLEN-1:0]        s1_mag_b;
    logic                   s1_neg;
    mul_ctl_t               s1_ctl;
    logic [TAG_W-1:0]       s1_tag;
    logic                   s2_valid;
    logic [2*XLEN-1:0]      s2_prod;
    logic                   s2_neg;
    mul_ctl_t               s2_ctl;
    logic [TAG_W-1:0]       s2_tag;
    mul_ctl_t               out_ctl;

    // Pack the incoming record.
    assign in_ctl = '{op: in_op, sgn: in_signed, word: in_word, so: in_so};

    mul_prep #(.XLEN(XLEN), .TAG_W(TAG_W)) u_prep (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_ctl(in_ctl), .in_tag(in_tag),
        .s1_valid(s1_valid), .s1_mag_a(s1_mag_a), .s1_mag_b(s1_mag_b),
        .s1_neg(s1_neg), .s1_ctl(s1_ctl), .s1_tag(s1_tag)
    );

    mul_core #(.XLEN(XLEN), .TAG_W(TAG_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_mag_a(s1_mag_a), .s1_mag_b(s1_mag_b),
        .s1_neg(s1_neg), .s1_ctl(s1_ctl), .s1_tag(s1_tag),
        .s2_valid(s2_valid), .s2_prod(s2_prod), .s2_neg(s2_neg),
        .s2_ctl(s2_ctl), .s2_tag(s2_tag)
    );

    mul_format #(.XLEN(XLEN), .TAG_W(TAG_W)) u_format (
        .clk(clk), .rst_n(rst_n),
        .s2_valid(s2_valid), .s2_prod(s2_prod), .s2_neg(s2_neg),
        .s2_ctl(s2_ctl), .s2_tag(s2_tag),
        .out_valid(out_valid), .out_result(out_result), .out_ov(out_ov),
        .out_ov_ok(out_ov_ok), .out_ctl(out_ctl), .out_tag(out_tag)
    );

    // Unpack the outgoing record.
    assign out_op     = out_ctl.op;
    assign out_signed = out_ctl.sgn;
    assign out_word   = out_ctl.word;
    assign out_so     = out_ctl.so;

    // Three-cycle latency across all stages.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3))
        |-> (out_valid == $past(in_valid, 3)));

    // Tag and summary bit leave with their own result.
    assert_record_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(in_valid, 3))
        |-> ((out_tag == $past(in_tag, 3)) && (out_so == $past(in_so, 3))));

endmodule

// File: tb/mul_pipe_test.sv
`timescale 1ns/1ps
module mul_pipe_test;
    localparam int X  = 8;
    localparam int H  = X / 2;
    localparam int T  = 2;
    localparam int PW = 2 * X;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [X-1:0]  in_a = '0;
    logic [X-1:0]  in_b = '0;
    logic [1:0]    in_op = 2'b00;
    logic          in_signed = 1'b0;
    logic          in_word = 1'b0;
    logic [T-1:0]  in_tag = '0;
    logic          in_so = 1'b0;
    logic          out_valid;
    logic [X-1:0]  out_result;
    logic [1:0]    out_ov;
    logic          out_ov_ok;
    logic [1:0]    out_op;
    logic          out_signed;
    logic          out_word;
    logic [T-1:0]  out_tag;
    logic          out_so;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    int n     = 0;

    logic          e_v   [8];
    logic [X-1:0]  e_res [8];
    logic [1:0]    e_ov  [8];
    logic          e_ok  [8];
    logic [4:0]    e_rec [8];
    logic [T-1:0]  e_tag [8];
    string         e_rq  [8];
    string         e_oq  [8];

    always #4 clk = ~clk;

    mul_pipe #(.XLEN(X), .TAG_W(T)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op(in_op), .in_signed(in_signed), .in_word(in_word), .in_tag(in_tag),
        .in_so(in_so), .out_valid(out_valid), .out_result(out_result), .out_ov(out_ov),
        .out_ov_ok(out_ov_ok), .out_op(out_op), .out_signed(out_signed),
        .out_word(out_word), .out_tag(out_tag), .out_so(out_so)
    );

    task automatic chk(input string rq, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, exp, n);
        end
    endtask

    function automatic logic [X-1:0] corner(input int i);
        case (i)
            0: corner = '0;
            1: corner = X'(1);
            2: corner = '1;
            3: corner = X'(1) << (X - 1);
            4: corner = X'(1) << (H - 1);
            5: corner = (X'(1) << H) - X'(1);
            6: corner = '1 >> 1;
            default: corner = ~((X'(1) << (H - 1)) - X'(1));
        endcase
    endfunction

    // Check the slot issued three cycles ago, then drive and record a new one.
    task automatic step(input logic v, input logic [X-1:0] a, input logic [X-1:0] b,
                        input logic [1:0] op, input logic sg, input logic wd);
        int s;
        logic            narrow, low, usg;
        logic [PW-1:0]   ea, eb, p;
        logic [X-H:0]    cn;
        logic [X:0]      cf;
        @(negedge clk);
        s = (n + 5) & 7;
        chk("R1", {{(PW-1){1'b0}}, out_valid}, {{(PW-1){1'b0}}, e_v[s]});
        if (e_v[s]) begin
            chk(e_rq[s], {{X{1'b0}}, out_result}, {{X{1'b0}}, e_res[s]});
            chk(e_oq[s], {{(PW-3){1'b0}}, out_ov_ok, out_ov}, {{(PW-3){1'b0}}, e_ok[s], e_ov[s]});
            chk("R2", {{(PW-5-T){1'b0}}, out_op, out_signed, out_word, out_so, out_tag},
                      {{(PW-5-T){1'b0}}, e_rec[s], e_tag[s]});
        end
        s = n & 7;
        low    = (op == 2'b00) || (op == 2'b11);
        narrow = (op == 2'b01) || (low && wd);
        usg    = sg || (low && !wd);
        if (narrow) begin
            ea = usg ? {{(PW-H){a[H-1]}}, a[H-1:0]} : {{(PW-H){1'b0}}, a[H-1:0]};
            eb = usg ? {{(PW-H){b[H-1]}}, b[H-1:0]} : {{(PW-H){1'b0}}, b[H-1:0]};
        end else begin
            ea = usg ? {{X{a[X-1]}}, a} : {{X{1'b0}}, a};
            eb = usg ? {{X{b[X-1]}}, b} : {{X{1'b0}}, b};
        end
        p  = ea * eb;
        cn = p[X-1:H-1];
        cf = p[PW-1:X-1];
        e_v[s]   = v;
        e_tag[s] = T'(n);
        e_rec[s] = {op, sg, wd, n[2]};
        if (op == 2'b01) begin
            e_res[s] = {p[X-1:H], p[X-1:H]}; e_rq[s] = "R3";
        end else if (op == 2'b10) begin
            e_res[s] = p[PW-1:X]; e_rq[s] = "R4";
        end else begin
            e_res[s] = p[X-1:0];
            e_rq[s] = (op == 2'b11) ? "R10" : (wd ? "R5" : "R6");
        end
        if (!low) begin
            e_ov[s] = 2'b00; e_ok[s] = 1'b0; e_oq[s] = "R9";
        end else if (wd) begin
            e_ov[s] = {2{(|cn) && !(&cn)}}; e_ok[s] = 1'b1; e_oq[s] = "R7";
        end else begin
            e_ov[s] = {2{(|cf) && !(&cf)}}; e_ok[s] = 1'b1; e_oq[s] = "R8";
        end
        in_valid = v; in_a = a; in_b = b; in_op = op; in_signed = sg; in_word = wd;
        in_tag = T'(n); in_so = n[2];
        n++;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) e_v[i] = 1'b0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11", {{(PW-X-4){1'b0}}, out_valid, out_result, out_ov, out_ov_ok}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // Corner operands, every mode, back to back
        for (int m = 0; m < 16; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    step(1'b1, corner(i), corner(j), m[3:2], m[1], m[0]);
        // Strided sweep across the operand space, every mode
        for (int m = 0; m < 16; m++)
            for (int a = 0; a < 256; a += 5)
                for (int b = 0; b < 256; b += 9)
                    step(1'b1, X'(a), X'(b), m[3:2], m[1], m[0]);
        // R1: bubbles between operations
        for (int i = 0; i < 40; i++)
            step(i[0] ^ i[2], X'(i * 37), X'(i * 11 + 3), i[4:3], i[1], i[2]);
        for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 2'b00, 1'b0, 1'b0);
        // R11: reset with operations in flight
        for (int i = 0; i < 3; i++) step(1'b1, X'(i + 3), '1, 2'b10, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11", {{(PW-X-4){1'b0}}, out_valid, out_result, out_ov, out_ov_ok}, '0);
        @(negedge clk);
        chk("R11", {{(PW-1){1'b0}}, out_valid}, '0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule